// File: doc/BRIEF.md
# Vectored Programmable Interrupt Controller

This block takes up to eight device request lines and drives one interrupt line to a processor. Software sets, for each line, whether it is blocked and whether it is sensed on a rising edge or on a held-high level. Lines have fixed priorities, and line 0 is the most urgent. The processor answers a raised interrupt with a one-cycle acknowledge pulse. On the following cycle the controller returns an 8-bit vector and a valid strobe. The vector is the winning line number added to a programmable base.

Each line that is granted is marked in service. It then holds off itself and every less urgent line until software writes an end-of-interrupt command that names it. A more urgent line can still interrupt, so service routines nest. If the request that raised the interrupt has gone away by the time the acknowledge arrives, the controller hands back a fixed spurious vector and marks nothing in service. The block leaves reset with every line blocked, edge-sensed and active-high, and with the base at 32. Device lines therefore never produce vectors 0 to 31 unless software moves the base.

Top module: `vecPic`

## Requirements
- R1: After reset the block-bits register reads 0xFF, the sense register reads 0x00, the base register reads 32, the in-service register reads 0x00, and `intOut` is low.
- R2: In edge mode (sense bit 0), a rising edge on an unblocked line latches a pending request. `intOut` rises after the next clock edge and stays high while the line stays high.
- R3: In level mode (sense bit 1), an unblocked line that is high drives `intOut` high in the same cycle. `intOut` falls in the same cycle when the line drops.
- R4: A line whose block bit is 1 never raises `intOut`.
- R5: When several lines request at once, the acknowledge grants the lowest-numbered line.
- R6: One cycle after an `ackIn` pulse, `vecValid` is high for exactly one cycle, and `vecOut` holds base plus the granted line number. The granted line's in-service bit sets.
- R7: If no eligible request remains when `ackIn` is sampled, `vecOut` returns the spurious vector (default 0xFF) and no in-service bit sets.
- R8: A line in service masks itself and all higher-numbered lines from `intOut`. Lower-numbered lines still raise it.
- R9: Writing address 3 with a line number in bits [2:0] clears that line's in-service bit on the next edge. Reading address 3 returns the in-service bits, with bit i standing for line i.
- R10: Writing address 2 sets the vector base, and later vectors use the new base.
- R11: Address 0 holds the block bits (1 = blocked) and address 1 holds the sense bits (1 = level). Both read back what was written, with bit i standing for line i.
- R12: An edge-mode pending request is consumed by its acknowledge. A line that stays high after its end-of-interrupt does not request again until it produces a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqIn | input | 8 | Device request lines, active high |
| ackIn | input | 1 | One-cycle acknowledge from the processor |
| intOut | output | 1 | Interrupt line to the processor |
| vecOut | output | 8 | Vector returned after an acknowledge |
| vecValid | output | 1 | High for one cycle while `vecOut` is fresh |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational from `regAddr` |

## Verification
The results arrive with different delays:

| Result | When it is due |
|---|---|
| `intOut`, level-mode line | same cycle as the input change |
| `intOut`, edge-mode line | one edge later, once the pending bit has latched |
| `vecOut` and `vecValid` | on the edge that samples `ackIn` |
| End-of-interrupt and register writes | on the edge that samples the write |
| Reads | combinational |

The bench drives every input on the falling edge. It samples a combinational result a nanosecond after driving it, and samples a registered result at the next falling edge. For edge mode it checks that `intOut` is still low before the latching edge and high after it. For level mode it checks both the rise and the fall in the same cycle as the input change.

// File: rtl/vpicPkg.sv
package vpicPkg;
  localparam int LINES = 8;
  localparam int IDX_W = $clog2(LINES);
  localparam int VEC_W = 8;
  localparam int ADR_W = 2;

  typedef enum logic [ADR_W-1:0] {
    ADDR_BLOCK = 2'd0,
    ADDR_SENSE = 2'd1,
    ADDR_BASE  = 2'd2,
    ADDR_EOI   = 2'd3
  } regAddrE;

  typedef struct packed {
    logic             grant;
    logic             spur;
    logic [IDX_W-1:0] grantIdx;
    logic             eoiHit;
    logic [IDX_W-1:0] eoiIdx;
    logic             wrBlock;
    logic             wrSense;
    logic             wrBase;
  } ctrlStrobeS;
endpackage

// File: rtl/vpicCtrl.sv
module vpicCtrl
  import vpicPkg::*;
(
  input  logic [LINES-1:0] irqIn,
  input  logic [LINES-1:0] blockQ,
  input  logic [LINES-1:0] senseQ,
  input  logic [LINES-1:0] pendQ,
  input  logic [LINES-1:0] isrQ,
  input  logic             ackIn,
  input  logic             regWe,
  input  logic [ADR_W-1:0] regAddr,
  input  logic [VEC_W-1:0] regWdata,
  output logic             intOut,
  output ctrlStrobeS       strb
);
  logic [LINES-1:0] eligible;
  logic [IDX_W:0]   ceilIdx;
  logic [IDX_W-1:0] winIdx;
  logic             found;

  // A line is live while its input is high; edge lines also need a latched edge.
  assign eligible = irqIn & (senseQ | pendQ) & ~blockQ;

  always_comb begin
    ceilIdx = (IDX_W+1)'(LINES);
    for (int i = LINES - 1; i >= 0; i--) begin
      if (isrQ[i]) ceilIdx = (IDX_W+1)'(i);
    end
  end

  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (eligible[i] && (i < int'(ceilIdx))) begin
        found  = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  assign intOut = found;

  always_comb begin
    strb          = '0;
    strb.grant    = ackIn & found;
    strb.spur     = ackIn & ~found;
    strb.grantIdx = winIdx;
    strb.eoiHit   = regWe && (regAddr == ADDR_EOI);
    strb.eoiIdx   = regWdata[IDX_W-1:0];
    strb.wrBlock  = regWe && (regAddr == ADDR_BLOCK);
    strb.wrSense  = regWe && (regAddr == ADDR_SENSE);
    strb.wrBase   = regWe && (regAddr == ADDR_BASE);
  end
endmodule

// File: rtl/vpicDp.sv
module vpicDp
  import vpicPkg::*;
#(
  parameter logic [VEC_W-1:0] DEF_BASE = 8'd32,
  parameter logic [VEC_W-1:0] SPUR_VEC = 8'hFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] irqIn,
  input  ctrlStrobeS       strb,
  input  logic [ADR_W-1:0] regAddr,
  input  logic [VEC_W-1:0] regWdata,
  output logic [LINES-1:0] blockQ,
  output logic [LINES-1:0] senseQ,
  output logic [LINES-1:0] pendQ,
  output logic [LINES-1:0] isrQ,
  output logic [VEC_W-1:0] vecOut,
  output logic             vecValid,
  output logic [VEC_W-1:0] regRdata
);
  logic [LINES-1:0] prevIrq;
  logic [VEC_W-1:0] baseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blockQ   <= '1;
      senseQ   <= '0;
      baseQ    <= DEF_BASE;
      prevIrq  <= '0;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      prevIrq  <= irqIn;
      vecValid <= strb.grant | strb.spur;
      if (strb.wrBlock) blockQ <= regWdata[LINES-1:0];
      if (strb.wrSense) senseQ <= regWdata[LINES-1:0];
      if (strb.wrBase)  baseQ  <= regWdata;
      if (strb.grant)     vecOut <= baseQ + VEC_W'(strb.grantIdx);
      else if (strb.spur) vecOut <= SPUR_VEC;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic hitGrant, hitEoi;
    assign hitGrant = strb.grant && (strb.grantIdx == IDX_W'(g));
    assign hitEoi   = strb.eoiHit && (strb.eoiIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendQ[g] <= 1'b0;
        isrQ[g]  <= 1'b0;
      end else begin
        // A latched edge is dropped when the line falls or is granted.
        pendQ[g] <= irqIn[g] & (pendQ[g] | ~prevIrq[g]) & ~hitGrant;
        isrQ[g]  <= hitGrant | (isrQ[g] & ~hitEoi);
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_BLOCK: regRdata = VEC_W'(blockQ);
      ADDR_SENSE: regRdata = VEC_W'(senseQ);
      ADDR_BASE:  regRdata = baseQ;
      default:    regRdata = VEC_W'(isrQ);
    endcase
  end
endmodule

// File: rtl/vecPic.sv
module vecPic
  import vpicPkg::*;
#(
  parameter logic [7:0] DEF_BASE = 8'd32,
  parameter logic [7:0] SPUR_VEC = 8'hFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] irqIn,
  input  logic       ackIn,
  output logic       intOut,
  output logic [7:0] vecOut,
  output logic       vecValid,
  input  logic       regWe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata
);
  ctrlStrobeS       strb;
  logic [LINES-1:0] blockQ, senseQ, pendQ, isrQ;

  vpicCtrl ctrl_i (
    .irqIn(irqIn), .blockQ(blockQ), .senseQ(senseQ), .pendQ(pendQ),
    .isrQ(isrQ), .ackIn(ackIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .intOut(intOut), .strb(strb)
  );

  vpicDp #(.DEF_BASE(DEF_BASE), .SPUR_VEC(SPUR_VEC)) dp_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strb(strb),
    .regAddr(regAddr), .regWdata(regWdata), .blockQ(blockQ),
    .senseQ(senseQ), .pendQ(pendQ), .isrQ(isrQ), .vecOut(vecOut),
    .vecValid(vecValid), .regRdata(regRdata)
  );
endmodule

// File: rtl/vecPicChk.sv
module vecPicChk #(
  parameter logic [7:0] SPUR_VEC = 8'hFF
) (
  input logic       clk,
  input logic       rstN,
  input logic       ackIn,
  input logic       intOut,
  input logic [7:0] vecOut,
  input logic       vecValid,
  input logic       regWe,
  input logic [1:0] regAddr,
  input logic [7:0] regWdata,
  input logic [7:0] isrBits,
  input logic [7:0] blockBits
);
  assert_ack_vec_R6: assert property (@(posedge clk) disable iff (!rstN)
    ackIn |=> vecValid);
  assert_vld_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ackIn |=> !vecValid);
  assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rstN)
    ackIn |=> $countones(isrBits & ~$past(isrBits)) <= 1);
  assert_blocked_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (&blockBits) |-> !intOut);
  assert_top_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    isrBits[0] |-> !intOut);
  assert_spurious_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !intOut) |=> (vecValid && vecOut == SPUR_VEC && $stable(isrBits)));
  assert_eoi_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd3 && !ackIn) |=> !isrBits[$past(regWdata[2:0])]);
endmodule

bind vecPic vecPicChk #(.SPUR_VEC(SPUR_VEC)) chk_i (
  .clk(clk), .rstN(rstN), .ackIn(ackIn), .intOut(intOut), .vecOut(vecOut),
  .vecValid(vecValid), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .isrBits(isrQ), .blockBits(blockQ)
);

// File: tb/vecPic_tb.sv
`timescale 1ns/1ps
module vecPic_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       ackIn = 1'b0;
  logic       intOut, vecValid;
  logic [7:0] vecOut, regRdata;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vecPic dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .ackIn(ackIn), .intOut(intOut),
    .vecOut(vecOut), .vecValid(vecValid), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    chk(tag, regRdata, exp);
  endtask

  task automatic ackChk(input string tag, input logic [7:0] exp);
    @(negedge clk);
    ackIn = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
    chk({tag, " valid"}, {7'd0, vecValid}, 8'd1);
    chk({tag, " vector"}, vecOut, exp);
    step();
    chk({tag, " valid pulse"}, {7'd0, vecValid}, 8'd0);
  endtask

  task automatic testReset();
    rdChk("R1 block", 2'd0, 8'hFF);
    rdChk("R1 sense", 2'd1, 8'h00);
    rdChk("R1 base", 2'd2, 8'd32);
    rdChk("R1 isr", 2'd3, 8'h00);
    chk("R1 intOut", {7'd0, intOut}, 8'd0);
  endtask

  task automatic testEdge();
    wr(2'd0, 8'hF7);
    rdChk("R11 block readback", 2'd0, 8'hF7);
    irqIn[3] = 1'b1;
    #1 chk("R2 before latch", {7'd0, intOut}, 8'd0);
    step();
    chk("R2 after latch", {7'd0, intOut}, 8'd1);
    step();
    chk("R2 held", {7'd0, intOut}, 8'd1);
    ackChk("R6 line3", 8'd35);
    rdChk("R6 isr set", 2'd3, 8'h08);
    chk("R8 self blocked", {7'd0, intOut}, 8'd0);
    wr(2'd3, 8'd3);
    rdChk("R9 eoi clears", 2'd3, 8'h00);
    chk("R12 no rerequest", {7'd0, intOut}, 8'd0);
    irqIn[3] = 1'b0;
    step();
  endtask

  task automatic testPriority();
    wr(2'd0, 8'h00);
    irqIn[5] = 1'b1; irqIn[2] = 1'b1;
    step();
    chk("R5 int", {7'd0, intOut}, 8'd1);
    ackChk("R5 lowest wins", 8'd34);
    chk("R8 line5 held off", {7'd0, intOut}, 8'd0);
    irqIn[0] = 1'b1;
    step();
    chk("R8 nesting", {7'd0, intOut}, 8'd1);
    ackChk("R8 nested vector", 8'd32);
    rdChk("R8 isr nested", 2'd3, 8'h05);
    wr(2'd3, 8'd0);
    chk("R8 still blocked by 2", {7'd0, intOut}, 8'd0);
    wr(2'd3, 8'd2);
    chk("R9 released", {7'd0, intOut}, 8'd1);
    ackChk("R5 line5", 8'd37);
    wr(2'd3, 8'd5);
    rdChk("R9 isr empty", 2'd3, 8'h00);
    irqIn = '0;
    step();
  endtask

  task automatic testLevel();
    wr(2'd1, 8'h40);
    rdChk("R11 sense readback", 2'd1, 8'h40);
    irqIn[6] = 1'b1;
    #1 chk("R3 same cycle rise", {7'd0, intOut}, 8'd1);
    step();
    irqIn[6] = 1'b0;
    #1 chk("R3 same cycle fall", {7'd0, intOut}, 8'd0);
    irqIn[6] = 1'b1;
    ackChk("R3 level vector", 8'd38);
    chk("R8 level in service", {7'd0, intOut}, 8'd0);
    wr(2'd3, 8'd6);
    chk("R3 level reasserts", {7'd0, intOut}, 8'd1);
    irqIn[6] = 1'b0;
    #1 chk("R3 level drop", {7'd0, intOut}, 8'd0);
    wr(2'd1, 8'h00);
  endtask

  task automatic testBlock();
    wr(2'd0, 8'hFF);
    irqIn[4] = 1'b1;
    repeat (3) step();
    chk("R4 blocked edge", {7'd0, intOut}, 8'd0);
    irqIn[4] = 1'b0;
    step();
    wr(2'd0, 8'h00);
  endtask

  task automatic testSpurious();
    irqIn[1] = 1'b1;
    step();
    chk("R7 raised", {7'd0, intOut}, 8'd1);
    irqIn[1] = 1'b0;
    #1 chk("R7 dropped", {7'd0, intOut}, 8'd0);
    ackChk("R7 spurious", 8'hFF);
    rdChk("R7 no isr", 2'd3, 8'h00);
  endtask

  task automatic testBase();
    wr(2'd2, 8'h40);
    rdChk("R10 base readback", 2'd2, 8'h40);
    irqIn[7] = 1'b1;
    step();
    ackChk("R10 new base", 8'h47);
    wr(2'd3, 8'd7);
    irqIn[7] = 1'b0;
    step();
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    testReset();
    testEdge();
    testPriority();
    testLevel();
    testBlock();
    testSpurious();
    testBase();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule